// File: doc/BRIEF.md
# Gain-Switch Settling Sequencer

This block controls when an acquisition chain may trust its converter after the amplifier range or the input channel has been changed. A request carries a range code, a channel number, a source-impedance class and an averaging exponent. Once the request is taken, the block drives the new range code and channel select onto its control outputs and waits a settle time. It then throws away a number of dummy conversions. Only after that does it open its valid window, add up 2^L conversions and deliver their average. The average is tagged with the range and channel that produced it.

The settle time and the dummy count come from a small table. The table has one entry per pair of range code and impedance class, and a plain write port loads it. The request, sample and result interfaces are valid/ready streams:

- **Requests.** A request waits, with back-pressure, until the previous result has been handed off.
- **Samples.** Conversions are drawn only during the settle, dummy and window phases.
- **Results.** A result is held steady until the consumer takes it.

A conversion flagged over-range counts as a disturbance, so the invalid phases run again before any sample is trusted.

Top module: `settle_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle (`busy` low). When a request is taken, `gain_code` and `chan_sel` show the request's range and channel from the next cycle, and `busy` rises.
- R2: The table entry used is at address {zcls, range}, that is zcls*8 + range. Its wait value W and dummy value D are copied when the request is taken. The settle phase then lasts W+1 cycles, and any conversion taken during it is discarded.
- R3: After the settle phase, the next D conversions are discarded. When D is 0, the window opens directly after the settle phase.
- R4: The window collects M = 2^L conversions, where L is `req_avg_log2` clamped to at most 8. `res_data` equals floor(sum / M) of exactly those conversions.
- R5: A conversion with `adc_ovr` high, taken in the settle, dummy or window phase, has three effects:
  - the partial sum is dropped;
  - W and D are reloaded from the copy made when the request was taken;
  - the settle phase restarts.
- R6: `res_valid` stays high with stable data and tags until `res_ready` is high. `adc_ready` is low while idle and while a result waits.
- R7: `res_range` and `res_chan` carry the range code and channel that were in force during the window.
- R8: `gain_code` and `chan_sel` do not change while `busy` is high.
- R9: After reset the block is idle. `gain_code`, `chan_sel` and `res_valid` are 0, and every table entry holds W = 0 and D = 0.
- R10: A table write takes effect only for requests taken after it. This holds even when the write happens in the same cycle as the acceptance or while a request is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry, {zcls, range} |
| cfg_wait | input | 16 | Settle cycles W for the entry |
| cfg_dummy | input | 8 | Dummy conversion count D for the entry |
| req_valid | input | 1 | Switch request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_range | input | 3 | Requested range (gain) code |
| req_zcls | input | 1 | Source-impedance class |
| req_chan | input | 4 | Requested input channel |
| req_avg_log2 | input | 4 | Averaging exponent L (clamped to 8) |
| gain_code | output | 3 | Applied range code |
| chan_sel | output | 4 | Applied channel select |
| adc_valid | input | 1 | Conversion present |
| adc_ready | output | 1 | Conversion consumed this cycle if valid |
| adc_data | input | 16 | Conversion value, unsigned |
| adc_ovr | input | 1 | Conversion flagged over-range |
| res_valid | output | 1 | Averaged result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Averaged value |
| res_range | output | 3 | Range code tag of the result |
| res_chan | output | 4 | Channel tag of the result |
| busy | output | 1 | A request is being served |

## Verification
Some properties are checked by assertions on every cycle:
- the control outputs stay frozen while busy and take the request values one cycle after acceptance;
- the result and its tags are held under back-pressure;
- no conversion is drawn while a result waits;
- a result is never presented in the cycle after a request is taken.

The bench's scenarios are needed for the rest. These are the exact phase lengths and the number of conversions discarded, the averaged value itself, and the restart after an over-range flag. They also cover the clamp of L and the timing of table writes against acceptance. A behavioural model predicts all of these cycle by cycle, and directed cases fix the expected averages by hand.

// File: rtl/settle_pkg.sv
package settle_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_DUMMY,
    PH_WINDOW,
    PH_HOLD
  } phase_t;
endpackage

// File: rtl/settle_table.sv
module settle_table #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 4,
  parameter int WAIT_W = 16,
  parameter int DUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WAIT_W-1:0] wr_wait,
  input  logic [DUM_W-1:0]  wr_dum,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WAIT_W-1:0] rd_wait,
  output logic [DUM_W-1:0]  rd_dum
);
  logic [WAIT_W-1:0] wait_q [N_ENT];
  logic [DUM_W-1:0]  dum_q  [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wait_q[g] <= '0;
        dum_q[g]  <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(g)) begin
        wait_q[g] <= wr_wait;
        dum_q[g]  <= wr_dum;
      end
    end
  end

  assign rd_wait = wait_q[rd_addr];
  assign rd_dum  = dum_q[rd_addr];
endmodule

// File: rtl/settle_accum.sv
module settle_accum #(
  parameter int DATA_W  = 16,
  parameter int MAX_LOG = 8,
  parameter int LOG_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      add,
  input  logic [DATA_W-1:0]         din,
  input  logic [LOG_W-1:0]          log2m,
  output logic [DATA_W+MAX_LOG-1:0] sum_next,
  output logic                      last
);
  localparam int ACC_W = DATA_W + MAX_LOG;
  localparam int CNT_W = MAX_LOG + 1;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] lim;

  assign sum_next = acc_q + ACC_W'(din);
  assign lim      = (CNT_W'(1) << log2m) - CNT_W'(1);
  assign last     = (n_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (add) begin
      acc_q <= sum_next;
      n_q   <= n_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/settle_seq.sv
module settle_seq
  import settle_pkg::*;
#(
  parameter int N_RANGE = 8,
  parameter int N_ZCLS  = 2,
  parameter int CHAN_W  = 4,
  parameter int DATA_W  = 16,
  parameter int WAIT_W  = 16,
  parameter int DUM_W   = 8,
  parameter int MAX_LOG = 8,
  localparam int RANGE_W = $clog2(N_RANGE),
  localparam int ZCLS_W  = $clog2(N_ZCLS),
  localparam int ADDR_W  = RANGE_W + ZCLS_W,
  localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic [DUM_W-1:0]   cfg_dummy,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [RANGE_W-1:0] req_range,
  input  logic [ZCLS_W-1:0]  req_zcls,
  input  logic [CHAN_W-1:0]  req_chan,
  input  logic [LOG_W-1:0]   req_avg_log2,
  output logic [RANGE_W-1:0] gain_code,
  output logic [CHAN_W-1:0]  chan_sel,
  input  logic               adc_valid,
  output logic               adc_ready,
  input  logic [DATA_W-1:0]  adc_data,
  input  logic               adc_ovr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [DATA_W-1:0]  res_data,
  output logic [RANGE_W-1:0] res_range,
  output logic [CHAN_W-1:0]  res_chan,
  output logic               busy
);
  localparam int N_ENT = N_RANGE * N_ZCLS;
  localparam int ACC_W = DATA_W + MAX_LOG;

  phase_t             ph_q;
  logic [WAIT_W-1:0]  wcnt_q, wload_q;
  logic [DUM_W-1:0]   dcnt_q, dload_q;
  logic [LOG_W-1:0]   log_q, log_clamp;
  logic [RANGE_W-1:0] gain_q, rrange_q;
  logic [CHAN_W-1:0]  chan_q, rchan_q;
  logic [DATA_W-1:0]  res_q;
  logic [WAIT_W-1:0]  tab_wait;
  logic [DUM_W-1:0]   tab_dum;
  logic [ACC_W-1:0]   sum_next, shifted;
  logic               acc_last, hs, disturb, acc_clr, acc_add;

  settle_table #(
    .N_ENT(N_ENT), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .DUM_W(DUM_W)
  ) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_wait(cfg_wait), .wr_dum(cfg_dummy),
    .rd_addr({req_zcls, req_range}), .rd_wait(tab_wait), .rd_dum(tab_dum)
  );

  settle_accum #(
    .DATA_W(DATA_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
    .din(adc_data), .log2m(log_q), .sum_next(sum_next), .last(acc_last)
  );

  assign adc_ready = (ph_q == PH_SETTLE) || (ph_q == PH_DUMMY) || (ph_q == PH_WINDOW);
  assign hs        = adc_valid && adc_ready;
  assign disturb   = hs && adc_ovr;
  assign acc_clr   = (ph_q == PH_IDLE) || disturb;
  assign acc_add   = (ph_q == PH_WINDOW) && hs && !adc_ovr;
  assign log_clamp = (req_avg_log2 > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : req_avg_log2;
  assign shifted   = sum_next >> log_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      wcnt_q   <= '0;
      wload_q  <= '0;
      dcnt_q   <= '0;
      dload_q  <= '0;
      log_q    <= '0;
      gain_q   <= '0;
      chan_q   <= '0;
      res_q    <= '0;
      rrange_q <= '0;
      rchan_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_valid) begin
          gain_q  <= req_range;
          chan_q  <= req_chan;
          log_q   <= log_clamp;
          wload_q <= tab_wait;
          dload_q <= tab_dum;
          wcnt_q  <= tab_wait;
          dcnt_q  <= tab_dum;
          ph_q    <= PH_SETTLE;
        end
        PH_SETTLE, PH_DUMMY, PH_WINDOW: begin
          if (disturb) begin
            wcnt_q <= wload_q;
            dcnt_q <= dload_q;
            ph_q   <= PH_SETTLE;
          end else if (ph_q == PH_SETTLE) begin
            if (wcnt_q == '0) ph_q <= (dcnt_q == '0) ? PH_WINDOW : PH_DUMMY;
            else              wcnt_q <= wcnt_q - WAIT_W'(1);
          end else if (ph_q == PH_DUMMY) begin
            if (hs) begin
              if (dcnt_q == DUM_W'(1)) ph_q <= PH_WINDOW;
              dcnt_q <= dcnt_q - DUM_W'(1);
            end
          end else if (hs && acc_last) begin
            res_q    <= shifted[DATA_W-1:0];
            rrange_q <= gain_q;
            rchan_q  <= chan_q;
            ph_q     <= PH_HOLD;
          end
        end
        PH_HOLD: if (res_ready) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign busy      = (ph_q != PH_IDLE);
  assign res_valid = (ph_q == PH_HOLD);
  assign gain_code = gain_q;
  assign chan_sel  = chan_q;
  assign res_data  = res_q;
  assign res_range = rrange_q;
  assign res_chan  = rchan_q;
endmodule

// File: rtl/settle_chk.sv
module settle_chk #(
  parameter int RANGE_W = 3,
  parameter int CHAN_W  = 4,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [RANGE_W-1:0] req_range,
  input logic [CHAN_W-1:0]  req_chan,
  input logic [RANGE_W-1:0] gain_code,
  input logic [CHAN_W-1:0]  chan_sel,
  input logic               adc_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [DATA_W-1:0]  res_data,
  input logic [RANGE_W-1:0] res_range,
  input logic [CHAN_W-1:0]  res_chan,
  input logic               busy
);
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R1
  AST_SWITCH_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && gain_code == $past(req_range) && chan_sel == $past(req_chan))); // R1
  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !res_valid); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_range) && $stable(res_chan))); // R6
  AST_NO_DRAW_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !adc_ready); // R6
  AST_RESULT_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_range == gain_code && res_chan == chan_sel)); // R7
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(gain_code) && $stable(chan_sel))); // R8
endmodule

bind settle_seq settle_chk #(
  .RANGE_W(RANGE_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_range(req_range), .req_chan(req_chan), .gain_code(gain_code),
  .chan_sel(chan_sel), .adc_ready(adc_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_range(res_range),
  .res_chan(res_chan), .busy(busy)
);

// File: tb/sim_settle_seq.sv
module sim_settle_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we, req_valid, req_ready, req_zcls, adc_valid, adc_ready, adc_ovr;
  logic res_valid, res_ready, busy;
  logic [3:0] cfg_addr, req_chan, req_avg_log2, chan_sel, res_chan;
  logic [15:0] cfg_wait, adc_data, res_data;
  logic [7:0] cfg_dummy;
  logic [2:0] req_range, gain_code, res_range;

  settle_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wait(cfg_wait),
    .cfg_dummy(cfg_dummy), .req_valid(req_valid), .req_ready(req_ready), .req_range(req_range),
    .req_zcls(req_zcls), .req_chan(req_chan), .req_avg_log2(req_avg_log2),
    .gain_code(gain_code), .chan_sel(chan_sel), .adc_valid(adc_valid), .adc_ready(adc_ready),
    .adc_data(adc_data), .adc_ovr(adc_ovr), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_range(res_range), .res_chan(res_chan), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0;
  // reference model: 0 idle, 1 settle, 2 dummy, 3 window, 4 result held
  int m_st = 0, m_w = 0, m_d = 0, m_wl = 0, m_dl = 0, m_n = 0, m_sum = 0, m_L = 0;
  int m_gain = 0, m_chan = 0, m_res = 0, m_rr = 0, m_rc = 0;
  int tw[16], td[16];
  // stimulus knobs
  int seq = 0, ovr_at = -1, p_adc = 0, p_ovr = 0, p_res = 100, p_req = 0, p_cfg = 0;
  bit cnt_mode = 0, hold_req = 0, got_res = 0;
  int hr_r = 0, hr_z = 0, hr_c = 0, hr_l = 0, last_res = 0, last_rr = 0, last_rc = 0;
  int cq_a[$], cq_w[$], cq_d[$];

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic step();
    int idx;
    @(negedge clk);
    chk("R1 req_ready", int'(req_ready), int'(m_st == 0));
    chk("R1 busy", int'(busy), int'(m_st != 0));
    chk("R8 gain_code", int'(gain_code), m_gain);
    chk("R8 chan_sel", int'(chan_sel), m_chan);
    chk("R2 adc_ready", int'(adc_ready), int'(m_st >= 1 && m_st <= 3));
    chk("R6 res_valid", int'(res_valid), int'(m_st == 4));
    if (m_st == 4) begin
      chk("R4 res_data", int'(res_data), m_res);
      chk("R7 res_range", int'(res_range), m_rr);
      chk("R7 res_chan", int'(res_chan), m_rc);
    end
    // drive inputs for the next rising edge
    if (cq_a.size() > 0) begin
      cfg_we = 1; cfg_addr = 4'(cq_a.pop_front());
      cfg_wait = 16'(cq_w.pop_front()); cfg_dummy = 8'(cq_d.pop_front());
    end else begin
      cfg_we = (($urandom % 100) < p_cfg);
      cfg_addr = 4'($urandom); cfg_wait = 16'($urandom % 20); cfg_dummy = 8'($urandom % 6);
    end
    if (hold_req) begin
      req_valid = 1; req_range = 3'(hr_r); req_zcls = hr_z[0]; req_chan = 4'(hr_c);
      req_avg_log2 = 4'(hr_l);
      if (req_ready) hold_req = 0;
    end else begin
      req_valid = (($urandom % 100) < p_req);
      req_range = 3'($urandom); req_zcls = 1'($urandom); req_chan = 4'($urandom);
      req_avg_log2 = (($urandom % 10) == 0) ? 4'd15 : 4'($urandom % 4);
    end
    if (cnt_mode) begin
      adc_valid = 1; adc_data = 16'(seq); adc_ovr = (seq == ovr_at);
      if (adc_ready) seq++;
    end else begin
      adc_valid = (($urandom % 100) < p_adc);
      adc_data = 16'($urandom); adc_ovr = (($urandom % 100) < p_ovr);
    end
    res_ready = (($urandom % 100) < p_res);
    if (res_valid && res_ready) begin
      got_res = 1; last_res = int'(res_data); last_rr = int'(res_range); last_rc = int'(res_chan);
    end
    // advance the model to the state after the next rising edge
    if (m_st == 0) begin
      if (req_valid) begin
        idx = int'(req_zcls) * 8 + int'(req_range);
        m_gain = int'(req_range); m_chan = int'(req_chan);
        m_L = (int'(req_avg_log2) > 8) ? 8 : int'(req_avg_log2);
        m_wl = tw[idx]; m_dl = td[idx]; m_w = m_wl; m_d = m_dl;
        m_n = 0; m_sum = 0; m_st = 1;
      end
    end else if (m_st == 4) begin
      if (res_ready) m_st = 0;
    end else if (adc_valid && adc_ovr) begin
      m_w = m_wl; m_d = m_dl; m_n = 0; m_sum = 0; m_st = 1;
    end else if (m_st == 1) begin
      if (m_w == 0) m_st = (m_d == 0) ? 3 : 2;
      else m_w--;
    end else if (m_st == 2) begin
      if (adc_valid) begin
        if (m_d == 1) m_st = 3;
        m_d--;
      end
    end else if (adc_valid) begin
      m_sum += int'(adc_data); m_n++;
      if (m_n == (1 << m_L)) begin
        m_res = m_sum >> m_L; m_rr = m_gain; m_rc = m_chan; m_st = 4;
      end
    end
    if (cfg_we) begin
      tw[int'(cfg_addr)] = int'(cfg_wait); td[int'(cfg_addr)] = int'(cfg_dummy);
    end
  endtask

  task automatic run_req(int z, int r, int c, int l, int ovr);
    seq = 0; ovr_at = ovr; cnt_mode = 1; got_res = 0;
    hold_req = 1; hr_z = z; hr_r = r; hr_c = c; hr_l = l;
    for (int i = 0; i < 3000 && !got_res; i++) step();
    cnt_mode = 0; ovr_at = -1;
    step();
  endtask

  task automatic cfg(int a, int w, int d);
    cq_a.push_back(a); cq_w.push_back(w); cq_d.push_back(d);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin tw[i] = 0; td[i] = 0; end
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wait = 0; cfg_dummy = 0;
    req_valid = 0; req_range = 0; req_zcls = 0; req_chan = 0; req_avg_log2 = 0;
    adc_valid = 0; adc_data = 0; adc_ovr = 0; res_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 res_valid after reset", int'(res_valid), 0);
    chk("R9 gain_code after reset", int'(gain_code), 0);
    chk("R9 chan_sel after reset", int'(chan_sel), 0);
    chk("R9 req_ready after reset", int'(req_ready), 1);

    // R2 R3: W=3 D=2 -> samples 0..5 dropped, window 6..9
    cfg(3, 3, 2); step();
    run_req(0, 3, 5, 2, -1);
    chk("R3 dummy discard average", last_res, 7);
    chk("R7 range tag", last_rr, 3);
    chk("R7 channel tag", last_rc, 5);

    // R5: flag on sample 7 restarts settle; window 14..17
    run_req(0, 3, 9, 2, 7);
    chk("R5 over-range restart average", last_res, 15);

    // R10: entry 8 is W=0 D=0; a write at the acceptance edge does not apply
    cfg(8, 0, 0); step();
    cfg(8, 1, 1);
    run_req(1, 0, 2, 0, -1);
    chk("R10 old entry used", last_res, 1);
    run_req(1, 0, 2, 1, -1);
    chk("R10 new entry used", last_res, 3);

    // R4: L=15 clamps to 8, window 3..258
    run_req(1, 0, 4, 15, -1);
    chk("R4 clamp to 256 samples", last_res, 130);

    // R1 R6 R8 R2: random traffic with back-pressure, over-range and table writes
    p_adc = 60; p_ovr = 2; p_res = 40; p_req = 30; p_cfg = 3;
    repeat (40000) step();
    p_adc = 95; p_ovr = 0; p_res = 90; p_req = 90; p_cfg = 0;
    repeat (20000) step();
    summary();
  end
endmodule